// File: doc/BRIEF.md
# Power-Domain Event Interrupt Collector

This block gathers seven single-cycle event pulses from a power-management domain, records each one in a pending register, and raises one level-sensitive interrupt toward a parent controller whenever a recorded event is also enabled. Software sees two 32-bit registers through a small word-addressed port: word 0 holds the pending bits and word 1 holds the enable bits. Both registers sit in bits 6:0; every bit above reads as zero.

The pending register is plain read/write. It is not write-one-to-clear. Whatever value software writes is the value each pending bit takes. To retire one source, software reads the register, clears that bit, and writes the result back. When a hardware pulse and a software write land on the same bit in the same cycle, the pulse takes priority, so no event is lost in that narrow window. Masking a source only takes it out of the interrupt line. It does not stop the event from being recorded.

Top module: `pwr_irq_collector`

## Requirements
- R1: After reset is released, both registers hold zero, irq_o is 0 and rdata_o is 0.
- R2: A 1 on evt_i[k] in a cycle sets pending bit k at that clock edge. The bit stays set until software writes 0 to it. Several inputs pulsing together all get recorded.
- R3: A write to word 0 (addr_i = 0) loads wdata_i[6:0] into the pending bits. A 1 sets a bit and a 0 clears it.
- R4: If evt_i[k] is 1 in the same cycle as a pending write that carries 0 in bit k, pending bit k ends up set.
- R5: A write to word 1 (addr_i = 1) loads wdata_i[6:0] into the enable bits. 1 enables a source and 0 disables it.
- R6: irq_o is 1 exactly when some bit is set in both pending and enable. It stays 1 for as long as that holds, with no pulse or edge behaviour.
- R7: A disabled source still records its event in the pending register. It only has no effect on irq_o.
- R8: A read (re_i = 1) returns the selected register in rdata_o one cycle later. The value is the contents before any write in that same cycle. rdata_o holds between reads, and reading changes no state.
- R9: Bits 31:7 of both registers read as 0 and ignore writes. Addresses 2 and 3 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event pulses, one per source |
| addr_i | input | 2 | Word address: 0 pending, 1 enable |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one cycle after re_i |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
The bench targets four corner cases:

- **Event and write collide on one bit.** A design that lets the write win would drop the event, and the readback would show the bit clear.
- **Read and write in the same cycle.** A design whose read port sampled the new value would return the written data instead of the old contents.
- **Event on a disabled source.** A design that gated capture with the enable would lose the pending bit, which would then never reach irq_o once the source is enabled.
- **Unused bits and addresses.** Writes of all ones to the upper bits and to unmapped words check that nothing leaks into readback or into irq_o. A per-source sweep confirms that every bit position drives the line independently.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;
  localparam int unsigned NUM_SRC_DEF = 7;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned ADDR_W_DEF  = 2;
  localparam int unsigned PEND_WORD   = 0;
  localparam int unsigned EN_WORD     = 1;
endpackage

// File: rtl/pir_pend_bank.sv
module pir_pend_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[k]) bit_q <= 1'b1;  // hardware set beats software write
      else if (wr_i)     bit_q <= wdata_i[k];
    end
    assign pend_o[k] = bit_q;
  end
endmodule

// File: rtl/pir_en_bank.sv
module pir_en_bank #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end
  assign en_o = en_q;
endmodule

// File: rtl/pir_rd_port.sv
module pir_rd_port #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               re_i,
  input  logic               sel_pend_i,
  input  logic               sel_en_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] sel_d;
  logic [DATA_W-1:0]  rdata_q;

  always_comb begin
    sel_d = '0;
    if (sel_pend_i)    sel_d = pend_i;
    else if (sel_en_i) sel_d = en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= {{PAD_W{1'b0}}, sel_d};
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/pir_irq_merge.sv
module pir_irq_merge #(
  parameter int unsigned NUM_SRC = 7
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               irq_o
);
  assign irq_o = |(pend_i & en_i);
endmodule

// File: rtl/pwr_irq_collector.sv
module pwr_irq_collector
  import pwr_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_SRC_DEF,
  parameter int unsigned DATA_W  = DATA_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic               sel_pend, sel_en;
  logic [NUM_SRC-1:0] pend_q, en_q;
  logic               unused_wdata;

  assign sel_pend     = (addr_i == ADDR_W'(PEND_WORD));
  assign sel_en       = (addr_i == ADDR_W'(EN_WORD));
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

  pir_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i & sel_pend),
    .wdata_i (wdata_i[NUM_SRC-1:0]),
    .evt_i   (evt_i),
    .pend_o  (pend_q)
  );

  pir_en_bank #(.NUM_SRC(NUM_SRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i & sel_en),
    .wdata_i (wdata_i[NUM_SRC-1:0]),
    .en_o    (en_q)
  );

  pir_rd_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (re_i),
    .sel_pend_i (sel_pend),
    .sel_en_i   (sel_en),
    .pend_i     (pend_q),
    .en_i       (en_q),
    .rdata_o    (rdata_o)
  );

  pir_irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .pend_i (pend_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/pwr_irq_collector_sva.sv
module pwr_irq_collector_sva #(
  parameter int unsigned NUM_SRC = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               re_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] en_q
);
  // R2, R4: an event always leaves its bit set
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_evt
    a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> pend_q[k]);
  end

  a_r3_pend_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(0) && evt_i == '0) |=> pend_q == $past(wdata_i[NUM_SRC-1:0]));

  a_r5_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(1)) |=> en_q == $past(wdata_i[NUM_SRC-1:0]));

  a_r6_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> irq_o);

  a_r8_no_side_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && evt_i == '0) |=> ($stable(pend_q) && $stable(en_q)));

  a_r8_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == ADDR_W'(0)) |=> rdata_o[NUM_SRC-1:0] == $past(pend_q));

  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_SRC] == '0);
endmodule

bind pwr_irq_collector pwr_irq_collector_sva #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .pend_q  (pend_q),
  .en_q    (en_q)
);

// File: tb/tb_pwr_irq_collector.sv
module tb_pwr_irq_collector;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  evt_i = '0;
  logic [1:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [6:0]  m_pend = '0;
  logic [6:0]  m_en   = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fl = 1'b0;

  always #4 clk_i = ~clk_i;

  pwr_irq_collector dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .re_i(re_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always @(posedge clk_i) rd_fl <= re_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [1:0] a);
    if (a == 2'd0) return {25'b0, m_pend};
    if (a == 2'd1) return {25'b0, m_en};
    return 32'b0;
  endfunction

  // monitor: pops one expected item per completed read
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_fl) begin
        if (exp_q.size() == 0) chk("R8 unexpected read", 32'd1, 32'd0);
        else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  // driver: one cycle of stimulus, then model update and level check
  task automatic cyc(input logic re, input logic we, input logic [1:0] a,
                     input logic [31:0] d, input logic [6:0] e, input string tag);
    re_i = re; we_i = we; addr_i = a; wdata_i = d; evt_i = e;
    if (re) begin
      exp_q.push_back(model_rd(a));
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    re_i = 0; we_i = 0; evt_i = '0;
    if (we && a == 2'd0) m_pend = d[6:0];
    if (we && a == 2'd1) m_en = d[6:0];
    m_pend |= e;
    chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", rdata_o, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    cyc(1, 0, 2'd0, 0, 0, "R1 pend");
    cyc(1, 0, 2'd1, 0, 0, "R1 en");

    // R2/R7: event on disabled source is recorded, irq stays low
    cyc(0, 0, 0, 0, 7'h04, "R7 masked evt");
    cyc(1, 0, 2'd0, 0, 0, "R2 R7 pend read");
    cyc(1, 0, 2'd0, 0, 0, "R8 reread no side effect");
    cyc(0, 0, 0, 0, 0, "R2 idle");
    cyc(1, 0, 2'd0, 0, 0, "R2 still set");

    // R5/R9: enable write with upper garbage
    cyc(0, 1, 2'd1, 32'hFFFF_FF04, 0, "R5 en write");
    cyc(1, 0, 2'd1, 0, 0, "R5 R9 en read");
    // R6 level persists
    repeat (3) cyc(0, 0, 0, 0, 0, "R6 level");

    // R3: clear and set via plain write
    cyc(0, 1, 2'd0, 32'h0, 0, "R3 clear");
    cyc(0, 1, 2'd0, 32'hFFFF_FF41, 0, "R3 set");
    cyc(1, 0, 2'd0, 0, 0, "R3 R9 pend read");
    cyc(0, 1, 2'd1, 32'h40, 0, "R6 enable bit6");

    // R4: collision, event wins
    cyc(0, 1, 2'd0, 32'h0, 7'h20, "R4 collide");
    cyc(1, 0, 2'd0, 0, 0, "R4 pend read");

    // R8: read and write same cycle returns old value
    cyc(1, 1, 2'd0, 32'h13, 0, "R8 rd+wr");
    cyc(1, 0, 2'd0, 0, 0, "R8 after wr");

    // R9: unmapped words
    cyc(0, 1, 2'd2, 32'hFFFF_FFFF, 0, "R9 wr addr2");
    cyc(0, 1, 2'd3, 32'hFFFF_FFFF, 0, "R9 wr addr3");
    cyc(1, 0, 2'd2, 0, 0, "R9 rd addr2");
    cyc(1, 0, 2'd3, 0, 0, "R9 rd addr3");
    cyc(1, 0, 2'd0, 0, 0, "R9 pend intact");
    cyc(1, 0, 2'd1, 0, 0, "R9 en intact");

    // R2: all sources at once
    cyc(0, 1, 2'd0, 32'h0, 0, "R2 clear");
    cyc(0, 0, 0, 0, 7'h7F, "R2 all evt");
    cyc(1, 0, 2'd0, 0, 0, "R2 all read");

    // R6 per-source sweep
    for (int k = 0; k < 7; k++) begin
      cyc(0, 1, 2'd0, 32'h0, 0, "R6 sweep clear");
      cyc(0, 1, 2'd1, 32'h1 << k, 0, "R6 sweep en");
      cyc(0, 0, 0, 0, 7'h7F & ~(7'h1 << k), "R6 sweep other");
      cyc(0, 0, 0, 0, 7'h1 << k, "R6 sweep own");
      cyc(0, 1, 2'd1, 32'h0, 0, "R5 sweep disable");
    end

    repeat (3) @(negedge clk_i);
    chk("R8 outstanding reads", exp_q.size(), 0);
    finish_run();
  end
endmodule